// File: doc/BRIEF.md
# Periodic Interrupt Down-Counter Timer

This block is a programmable periodic timer. A 16-bit down-counter is advanced by a clock-enable tick that is synchronous to the system clock. A 2-bit prescaler sits between the tick and the counter, so the counter takes one step for every four qualifying ticks. Each time the count steps from one to zero, a sticky status flag is set. On the next step the counter reloads from the period register, and the cycle repeats without software help. A registered, maskable level interrupt reflects the flag.

Software uses a small register port. A period register can be read and written. A control register holds the run enable and the interrupt enable, and it reads back the flag, which is cleared by writing a 1 to it. A live count register can only be read. Writing the period aborts the countdown under way, restarts the prescaler, and starts counting from the new value. Only the power-on reset clears the block. The ordinary system resets are not wired to it.

Top module: `pit_timer`

## Requirements
- R1: While `por_n` is low and after it rises, the live count reads 0, the period reads 0, all control bits read 0, and `irq` is 0.
- R2: The register selects are: 0 = period (read/write), 1 = control, 2 = live count (read only; writes are ignored), 3 = reads as 0. In the control register, bit 0 is run enable, bit 1 is interrupt enable and bit 2 is the flag. `rd_data` is combinational from `rd_sel`.
- R3: While run enable is 1, the counter takes one step on every fourth clock with `tick_en` high. While run enable is 0, the counter holds its value and the prescaler is cleared.
- R4: A write to the period loads the counter with the written value at that clock edge and clears the prescaler. This happens whether or not the timer is running.
- R5: A step that takes the count from 1 to 0 sets the flag at that same edge.
- R6: A step taken while the count is 0 reloads the counter from the period register. With a nonzero period N, one full cycle therefore takes N+1 steps.
- R7: A period of 0 gives a full cycle of 65536 steps: a step at count 0 wraps the counter to 0xFFFF.
- R8: The flag is sticky. Writing the control register with bit 2 set clears it. If that write lands on the same edge as a zero-crossing step, the flag stays set.
- R9: `irq` is registered. Each cycle it equals the flag AND interrupt enable as they stood one clock earlier. Clearing interrupt enable drops `irq` but leaves the flag set.
- R10: Reading any register has no effect on the count, the prescaler or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| tick_en | input | 1 | Timer tick qualifier, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 16 | Read data, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is a flag clear that lands on the very edge where the count crosses zero. At that edge the set and the clear compete, and the design must let the set win. The bench writes a period of 1 and issues exactly three ticks to bring the prescaler to its last phase. It then raises `tick_en` and the clearing control write in the same cycle. Two other checks need a part-filled prescaler before a period write or a run-enable drop. These show that the restart discards the partial phase.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_NONE   = 2'd3
  } pit_sel_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_IEN_BIT  = 1;
  localparam int CTRL_FLAG_BIT = 2;
endpackage

// File: rtl/pit_prescale.sv
module pit_prescale #(
  parameter int DIV_W = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic tick_en,
  input  logic run,
  input  logic restart,
  output logic step
);
  localparam logic [DIV_W-1:0] LAST = {DIV_W{1'b1}};

  logic [DIV_W-1:0] phase_q;

  assign step = tick_en && run && !restart && (phase_q == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 phase_q <= '0;
    else if (restart || !run)   phase_q <= '0;
    else if (tick_en)           phase_q <= phase_q + DIV_W'(1);
  end

  assert_step_qualified_R3: assert property (@(posedge clk) disable iff (!por_n)
    step |-> (tick_en && run));
  assert_idle_clears_R3: assert property (@(posedge clk) disable iff (!por_n)
    (!run || restart) |=> !step);
endmodule

// File: rtl/pit_count.sv
module pit_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             zero_hit
);
  function automatic logic [CNT_W-1:0] reload_of(input logic [CNT_W-1:0] p);
    return (p == '0) ? {CNT_W{1'b1}} : p;
  endfunction

  function automatic logic [CNT_W-1:0] after_step(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] p);
    return (c == '0) ? reload_of(p) : c - CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_q;

  assign count    = cnt_q;
  assign zero_hit = step && !load && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (step)  cnt_q <= after_step(cnt_q, period);
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
    (!load && !step) |=> $stable(cnt_q));
  assert_load_R4: assert property (@(posedge clk) disable iff (!por_n)
    load |=> (cnt_q == $past(load_val)));
  assert_zero_lands_R5: assert property (@(posedge clk) disable iff (!por_n)
    zero_hit |=> (cnt_q == '0));
endmodule

// File: rtl/pit_flag.sv
module pit_flag (
  input  logic clk,
  input  logic por_n,
  input  logic set,
  input  logic clr,
  input  logic ien,
  output logic flag,
  output logic irq
);
  logic flag_q, irq_q;

  assign flag = flag_q;
  assign irq  = irq_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (set)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
      irq_q <= flag_q && ien;
    end
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!por_n)
    set |=> flag_q);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!por_n)
    (flag_q && !clr) |=> flag_q);
  assert_no_flag_no_irq_R9: assert property (@(posedge clk) disable iff (!por_n)
    !flag_q |=> !irq_q);
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);
  logic [CNT_W-1:0] period_q, count;
  logic             run_q, ien_q, flag, step, zero_hit;
  logic             period_wr, ctrl_wr, flag_clr;

  assign period_wr = wr_en && (wr_sel == SEL_PERIOD);
  assign ctrl_wr   = wr_en && (wr_sel == SEL_CTRL);
  assign flag_clr  = ctrl_wr && wr_data[CTRL_FLAG_BIT];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      period_q <= '0;
      run_q    <= 1'b0;
      ien_q    <= 1'b0;
    end else begin
      if (period_wr) period_q <= wr_data;
      if (ctrl_wr) begin
        run_q <= wr_data[CTRL_RUN_BIT];
        ien_q <= wr_data[CTRL_IEN_BIT];
      end
    end
  end

  pit_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .por_n(por_n), .tick_en(tick_en), .run(run_q),
    .restart(period_wr), .step(step)
  );

  pit_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .por_n(por_n), .load(period_wr), .load_val(wr_data),
    .step(step), .period(period_q), .count(count), .zero_hit(zero_hit)
  );

  pit_flag u_flag (
    .clk(clk), .por_n(por_n), .set(zero_hit), .clr(flag_clr),
    .ien(ien_q), .flag(flag), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_PERIOD: rd_data = period_q;
      SEL_CTRL: begin
        rd_data[CTRL_RUN_BIT]  = run_q;
        rd_data[CTRL_IEN_BIT]  = ien_q;
        rd_data[CTRL_FLAG_BIT] = flag;
      end
      SEL_COUNT:  rd_data = count;
      default:    rd_data = '0;
    endcase
  end

  assert_period_kept_R2: assert property (@(posedge clk) disable iff (!por_n)
    !period_wr |=> $stable(period_q));
  assert_irq_needs_ien_R9: assert property (@(posedge clk) disable iff (!por_n)
    !ien_q |=> !irq);
  assert_reload_R6: assert property (@(posedge clk) disable iff (!por_n)
    (step && !period_wr && count == '0 && period_q != '0) |=> (count == $past(period_q)));
endmodule

// File: tb/pit_timer_tb.sv
module pit_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [15:0] rd_data;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pit_timer u_dut (
    .clk(clk), .por_n(por_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] ctrl_word(input bit run, input bit ien, input bit flg);
    return {13'd0, flg, ien, run};
  endfunction

  task automatic rd(input logic [1:0] sel, output logic [15:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(2'd2, v); chk("R1 count", v, 16'h0);
    rd(2'd0, v); chk("R1 period", v, 16'h0);
    rd(2'd1, v); chk("R1 ctrl", v, 16'h0);
    chk("R1 irq", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_hold_and_load;
    logic [15:0] v;
    wr(2'd0, 16'd3);
    rd(2'd2, v); chk("R4 load while stopped", v, 16'd3);
    rd(2'd0, v); chk("R2 period readback", v, 16'd3);
    tick(20);
    rd(2'd2, v); chk("R3 hold while run=0", v, 16'd3);
    wr(2'd2, 16'h1234);
    rd(2'd2, v); chk("R2 count is read-only", v, 16'd3);
    rd(2'd3, v); chk("R2 sel 3 reads zero", v, 16'h0);
  endtask

  task automatic t_countdown;
    logic [15:0] v;
    wr(2'd1, ctrl_word(1, 0, 0));
    tick(3);
    rd(2'd2, v); chk("R3 no step before 4th tick", v, 16'd3);
    tick(1);
    rd(2'd2, v); chk("R3 step on 4th tick", v, 16'd2);
    tick(4);
    rd(2'd2, v); chk("R3 second step", v, 16'd1);
    rd(2'd1, v); chk("R5 flag clear before zero", v, ctrl_word(1, 0, 0));
    tick(4);
    rd(2'd2, v); chk("R5 reached zero", v, 16'd0);
    rd(2'd1, v); chk("R5 flag set at zero", v, ctrl_word(1, 0, 1));
    idle(1);
    chk("R9 masked irq", {15'd0, irq}, 16'h0);
    tick(4);
    rd(2'd2, v); chk("R6 reload from period", v, 16'd3);
    rd(2'd1, v); chk("R8 flag sticky", v, ctrl_word(1, 0, 1));
  endtask

  task automatic t_irq;
    logic [15:0] v;
    wr(2'd1, ctrl_word(1, 1, 0));
    chk("R9 irq one clock late", {15'd0, irq}, 16'h0);
    idle(1);
    chk("R9 irq asserted", {15'd0, irq}, 16'h1);
    wr(2'd1, ctrl_word(1, 0, 0));
    idle(1);
    chk("R9 irq masked by ien", {15'd0, irq}, 16'h0);
    rd(2'd1, v); chk("R9 flag kept when masked", v, ctrl_word(1, 0, 1));
    wr(2'd1, ctrl_word(1, 1, 1));
    rd(2'd1, v); chk("R8 write-one clears flag", v, ctrl_word(1, 1, 0));
    idle(2);
    chk("R9 irq low after clear", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_divider_restart;
    logic [15:0] v;
    tick(2);
    wr(2'd0, 16'd5);
    tick(3);
    rd(2'd2, v); chk("R4 prescaler restarted by write", v, 16'd5);
    tick(1);
    rd(2'd2, v); chk("R4 first step after restart", v, 16'd4);
    tick(2);
    wr(2'd1, ctrl_word(0, 1, 0));
    wr(2'd1, ctrl_word(1, 1, 0));
    tick(3);
    rd(2'd2, v); chk("R3 prescaler cleared by run=0", v, 16'd4);
    tick(1);
    rd(2'd2, v); chk("R3 step after rerun", v, 16'd3);
  endtask

  task automatic t_collision;
    logic [15:0] v;
    wr(2'd0, 16'd1);
    tick(3);
    tick_en = 1'b1;
    wr(2'd1, ctrl_word(1, 1, 1));
    tick_en = 1'b0;
    rd(2'd2, v); chk("R5 zero on collision edge", v, 16'd0);
    rd(2'd1, v); chk("R8 zero beats clear", v, ctrl_word(1, 1, 1));
    idle(1);
    chk("R9 irq after collision", {15'd0, irq}, 16'h1);
    wr(2'd1, ctrl_word(1, 1, 1));
    idle(2);
    chk("R8 clear after collision", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_zero_period;
    logic [15:0] v;
    wr(2'd0, 16'd0);
    rd(2'd2, v); chk("R7 loaded zero", v, 16'd0);
    tick(4);
    rd(2'd2, v); chk("R7 wrap to ffff", v, 16'hFFFF);
    tick(4);
    rd(2'd2, v); chk("R7 count on from ffff", v, 16'hFFFE);
  endtask

  task automatic t_read_no_effect;
    logic [15:0] v;
    tick(2);
    for (int i = 0; i < 8; i++) begin
      rd(2'(i % 4), v);
      idle(1);
    end
    tick(1);
    rd(2'd2, v); chk("R10 reads leave count", v, 16'hFFFE);
    tick(1);
    rd(2'd2, v); chk("R10 reads leave prescaler", v, 16'hFFFD);
    rd(2'd1, v); chk("R10 reads leave flag", v, ctrl_word(1, 1, 0));
  endtask

  task automatic t_por_again;
    logic [15:0] v;
    por_n = 1'b0;
    #1;
    rd(2'd2, v); chk("R1 por clears count", v, 16'h0);
    rd(2'd1, v); chk("R1 por clears ctrl", v, 16'h0);
    idle(2);
    por_n = 1'b1;
    idle(1);
    t_reset();
  endtask

  initial begin
    idle(3);
    t_reset();
    por_n = 1'b1;
    idle(1);
    t_reset();
    t_hold_and_load();
    t_countdown();
    t_irq();
    t_divider_restart();
    t_collision();
    t_zero_period();
    t_read_no_effect();
    t_por_again();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule